// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the synchronous mode controller of a dimmable fluorescent lamp ballast. It receives comparator decisions that analog circuitry has already reduced to single bits: two supply thresholds, two line-voltage thresholds, two shutdown-pin thresholds, an over-temperature flag, a peak over-current flag and a flag that says the oscillator control level has fallen to the dimming threshold. From these it steps the ballast through lockout, preheat, ignition, dimming and a latched fault mode. Preheat length is measured by an internal cycle counter.

The outputs tell the rest of the ballast what to do. The block reports the current mode and enables the half-bridge. It arms the over-current check, asks the oscillator to return to its highest frequency, and clears the preheat timer. Every comparator flag is asynchronous to the clock, so each one passes through a two-flop synchroniser before the mode logic uses it. A change at a flag therefore acts on the mode register at the third rising clock edge after it.

Top module: `ballastSequencer`

## Requirements
- R1: After reset the mode output is 0, the bridge and the over-current check are off, and the frequency-reset and timer-clear outputs are high. Mode codes are 0 lockout, 1 preheat, 2 ignition, 3 dim and 4 fault.
- R2: Lockout is left for preheat only when three conditions hold together: supplyAboveHi is 1, busAboveOn is 1 and sdAboveLo is 0. The mode changes on the third rising edge after the inputs settle. If any one of the three is missing, the block stays in lockout.
- R3: From preheat, ignition or dim, the mode returns to lockout when supplyAboveLo goes to 0, when busAboveOff goes to 0, or when sdAboveHi goes to 1.
- R4: Preheat lasts exactly PREHEAT_CYCLES clock cycles and then passes to ignition. The preheat timer is held at zero in lockout and in fault.
- R5: peakOverCurrent has no effect in preheat. In ignition or dim it forces the fault mode.
- R6: overTemp forces the fault mode from preheat, ignition or dim.
- R7: Ignition passes to dim when dimThreshold is 1. dimThreshold has no effect in preheat.
- R8: bridgeEn is 1 only in preheat, ignition and dim. ocCheckEn is 1 only in ignition and dim. freqReset and timerClear are 1 only in lockout and fault.
- R9: The fault mode is latched. Clearing overTemp or peakOverCurrent, or dropping the line voltage, leaves it in place. It is left for lockout only when supplyAboveLo goes to 0 or sdAboveHi goes to 1. After that, the normal lockout exit restarts the ballast in preheat.
- R10: If a lockout condition and a fault condition arrive in the same cycle in an active mode, lockout wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyAboveHi | input | 1 | Supply is above the upper (start) threshold |
| supplyAboveLo | input | 1 | Supply is above the lower (stop) threshold |
| busAboveOn | input | 1 | Line sense is above the turn-on level |
| busAboveOff | input | 1 | Line sense is above the turn-off level |
| sdAboveHi | input | 1 | Shutdown pin is above its rising threshold |
| sdAboveLo | input | 1 | Shutdown pin is above its falling threshold |
| overTemp | input | 1 | Junction over-temperature |
| peakOverCurrent | input | 1 | Peak current-sense over-current |
| dimThreshold | input | 1 | Oscillator control level has reached the dim threshold |
| mode | output | 3 | Current mode code |
| bridgeEn | output | 1 | Half-bridge enable |
| ocCheckEn | output | 1 | Over-current detection armed |
| freqReset | output | 1 | Request to return the oscillator to maximum frequency |
| timerClear | output | 1 | Preheat timer held clear |

## Verification
The sequence is driven along a full start-up path: lockout, then preheat, ignition and dim. It is also driven with partial start conditions, which show that each of the three entry terms is needed on its own. Over-current and dim-threshold pulses are applied during preheat and again after it, which separates masked stimulus from live stimulus. Faults are followed first by releases that must not clear the latch and then by each of the two legal clearing paths. One coincident lockout-and-fault pattern shows the priority between the two. A behavioural model in the bench tracks the mode every cycle, so the exact transition cycles and the preheat length are compared as well as the end states.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    MODE_LOCKOUT = 3'd0,
    MODE_PREHEAT = 3'd1,
    MODE_IGNITE  = 3'd2,
    MODE_DIM     = 3'd3,
    MODE_FAULT   = 3'd4
  } modeT;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clearTimer;
    logic runTimer;
  } timerStrobeT;

  // bit positions inside the synchronised flag vector
  localparam int FLAG_SUP_HI  = 0;
  localparam int FLAG_SUP_LO  = 1;
  localparam int FLAG_BUS_ON  = 2;
  localparam int FLAG_BUS_OFF = 3;
  localparam int FLAG_SD_HI   = 4;
  localparam int FLAG_SD_LO   = 5;
  localparam int FLAG_OT      = 6;
  localparam int FLAG_OC      = 7;
  localparam int FLAG_DIM     = 8;
  localparam int FLAG_COUNT   = 9;

endpackage

// File: rtl/flagSync.sv
module flagSync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import ballast_pkg::*;
#(
  parameter int PREHEAT_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  timerStrobeT strobe,
  output logic        preheatDone
);

  localparam int CNT_W = $clog2(PREHEAT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREHEAT_CYCLES - 1);

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countQ <= '0;
    else if (strobe.clearTimer) countQ <= '0;
    else if (strobe.runTimer && countQ != LAST) countQ <= countQ + 1'b1;
  end

  assign preheatDone = (countQ == LAST);

  // R4: a clear strobe leaves the timer at zero on the next cycle
  assert_timer_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearTimer |=> countQ == '0);

  // R4: a running timer below its limit advances by one
  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runTimer && !strobe.clearTimer && countQ != LAST)
      |=> countQ == $past(countQ) + 1'b1);

endmodule

// File: rtl/seqControl.sv
module seqControl
  import ballast_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supHi,
  input  logic        supLo,
  input  logic        busOn,
  input  logic        busOff,
  input  logic        sdHi,
  input  logic        sdLo,
  input  logic        hot,
  input  logic        overCur,
  input  logic        dimReached,
  input  logic        preheatDone,
  output modeT        stateQ,
  output logic        bridgeEn,
  output logic        ocCheckEn,
  output logic        freqReset,
  output timerStrobeT strobe
);

  modeT stateD;
  logic startOk, dropOut, active, ocLive;

  assign startOk = supHi && busOn && !sdLo;
  assign dropOut = !supLo || !busOff || sdHi;
  assign active  = (stateQ == MODE_PREHEAT) || (stateQ == MODE_IGNITE) || (stateQ == MODE_DIM);
  assign ocLive  = (stateQ == MODE_IGNITE) || (stateQ == MODE_DIM);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      MODE_LOCKOUT: if (startOk) stateD = MODE_PREHEAT;
      MODE_PREHEAT: begin
        if (dropOut)          stateD = MODE_LOCKOUT;
        else if (hot)         stateD = MODE_FAULT;
        else if (preheatDone) stateD = MODE_IGNITE;
      end
      MODE_IGNITE: begin
        if (dropOut)             stateD = MODE_LOCKOUT;
        else if (hot || overCur) stateD = MODE_FAULT;
        else if (dimReached)     stateD = MODE_DIM;
      end
      MODE_DIM: begin
        if (dropOut)             stateD = MODE_LOCKOUT;
        else if (hot || overCur) stateD = MODE_FAULT;
      end
      MODE_FAULT: if (!supLo || sdHi) stateD = MODE_LOCKOUT;
      default: stateD = MODE_LOCKOUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= MODE_LOCKOUT;
    else       stateQ <= stateD;
  end

  assign bridgeEn          = active;
  assign ocCheckEn         = ocLive;
  assign freqReset         = !active;
  assign strobe.clearTimer = !active;
  assign strobe.runTimer   = (stateQ == MODE_PREHEAT);

  // R2: without all three start terms lockout is held
  assert_lockout_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_LOCKOUT && !(supHi && busOn && !sdLo)) |=> stateQ == MODE_LOCKOUT);

  // R5: over-current in preheat never produces a fault
  assert_oc_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_PREHEAT && !hot) |=> stateQ != MODE_FAULT);

  // R6: over-temperature in an active mode with no drop-out leads to fault
  assert_hot_fault_R6: assert property (@(posedge clk) disable iff (!rstN)
    (active && hot && supLo && busOff && !sdHi) |=> stateQ == MODE_FAULT);

  // R9: fault stays latched until supply drop or shutdown high
  assert_fault_latched_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_FAULT && supLo && !sdHi) |=> stateQ == MODE_FAULT);

  // R10: a line drop-out beats any fault source
  assert_dropout_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (active && !busOff) |=> stateQ == MODE_LOCKOUT);

endmodule

// File: rtl/ballastSequencer.sv
module ballastSequencer
  import ballast_pkg::*;
#(
  parameter int PREHEAT_CYCLES = 40,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyAboveHi,
  input  logic       supplyAboveLo,
  input  logic       busAboveOn,
  input  logic       busAboveOff,
  input  logic       sdAboveHi,
  input  logic       sdAboveLo,
  input  logic       overTemp,
  input  logic       peakOverCurrent,
  input  logic       dimThreshold,
  output logic [2:0] mode,
  output logic       bridgeEn,
  output logic       ocCheckEn,
  output logic       freqReset,
  output logic       timerClear
);

  logic [FLAG_COUNT-1:0] rawFlags, syncFlags;
  timerStrobeT strobe;
  logic preheatDone;
  modeT stateQ;

  always_comb begin
    rawFlags               = '0;
    rawFlags[FLAG_SUP_HI]  = supplyAboveHi;
    rawFlags[FLAG_SUP_LO]  = supplyAboveLo;
    rawFlags[FLAG_BUS_ON]  = busAboveOn;
    rawFlags[FLAG_BUS_OFF] = busAboveOff;
    rawFlags[FLAG_SD_HI]   = sdAboveHi;
    rawFlags[FLAG_SD_LO]   = sdAboveLo;
    rawFlags[FLAG_OT]      = overTemp;
    rawFlags[FLAG_OC]      = peakOverCurrent;
    rawFlags[FLAG_DIM]     = dimThreshold;
  end

  flagSync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawFlags), .syncOut(syncFlags)
  );

  seqControl uCtrl (
    .clk(clk), .rstN(rstN),
    .supHi(syncFlags[FLAG_SUP_HI]), .supLo(syncFlags[FLAG_SUP_LO]),
    .busOn(syncFlags[FLAG_BUS_ON]), .busOff(syncFlags[FLAG_BUS_OFF]),
    .sdHi(syncFlags[FLAG_SD_HI]),   .sdLo(syncFlags[FLAG_SD_LO]),
    .hot(syncFlags[FLAG_OT]),       .overCur(syncFlags[FLAG_OC]),
    .dimReached(syncFlags[FLAG_DIM]),
    .preheatDone(preheatDone),
    .stateQ(stateQ), .bridgeEn(bridgeEn), .ocCheckEn(ocCheckEn),
    .freqReset(freqReset), .strobe(strobe)
  );

  seqDatapath #(.PREHEAT_CYCLES(PREHEAT_CYCLES)) uTimer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preheatDone(preheatDone)
  );

  assign mode       = stateQ;
  assign timerClear = strobe.clearTimer;

  // R8: over-current checking is only armed while the bridge runs
  assert_oc_needs_bridge_R8: assert property (@(posedge clk) disable iff (!rstN)
    ocCheckEn |-> bridgeEn);

  // R8: bridge drive and frequency reset never overlap
  assert_bridge_vs_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({bridgeEn, freqReset}));

endmodule

// File: tb/tb_ballastSequencer.sv
`timescale 1ns/1ps
module tb_ballastSequencer;

  localparam int PH = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic supHi = 0, supLo = 0, busOn = 0, busOff = 0;
  logic sdHi = 0, sdLo = 0, ot = 0, oc = 0, dimT = 0;
  logic [2:0] mode;
  logic bridgeEn, ocCheckEn, freqReset, timerClear;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ballastSequencer #(.PREHEAT_CYCLES(PH)) dut (
    .clk(clk), .rstN(rstN),
    .supplyAboveHi(supHi), .supplyAboveLo(supLo),
    .busAboveOn(busOn), .busAboveOff(busOff),
    .sdAboveHi(sdHi), .sdAboveLo(sdLo),
    .overTemp(ot), .peakOverCurrent(oc), .dimThreshold(dimT),
    .mode(mode), .bridgeEn(bridgeEn), .ocCheckEn(ocCheckEn),
    .freqReset(freqReset), .timerClear(timerClear)
  );

  // behavioural reference: inputs seen two edges late, mode as an integer
  int refMode = 0, refCnt = 0;
  logic [8:0] inHist[$];

  always @(posedge clk) begin
    logic [8:0] f;
    bit drop;
    if (!rstN) begin
      refMode = 0; refCnt = 0; inHist.delete();
    end else begin
      inHist.push_back({dimT, oc, ot, sdLo, sdHi, busOff, busOn, supLo, supHi});
      f = (inHist.size() > 2) ? inHist.pop_front() : 9'd0;
      drop = !f[1] || !f[3] || f[4];
      case (refMode)
        0: if (f[0] && f[2] && !f[5]) refMode = 1;
        1: if (drop) refMode = 0;
           else if (f[6]) refMode = 4;
           else if (refCnt == PH - 1) refMode = 2;
           else refCnt++;
        2: if (drop) refMode = 0;
           else if (f[6] || f[7]) refMode = 4;
           else if (f[8]) refMode = 3;
        3: if (drop) refMode = 0;
           else if (f[6] || f[7]) refMode = 4;
        default: if (!f[1] || f[4]) refMode = 0;
      endcase
      if (refMode == 0 || refMode == 4) refCnt = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit act;
      act = (refMode >= 1 && refMode <= 3);
      checks++;
      if (mode != 3'(refMode) || bridgeEn != act || freqReset != !act ||
          timerClear != !act || ocCheckEn != (refMode == 2 || refMode == 3)) begin
        fails++;
        $display("FAIL model (mode R2, outputs R8) t=%0t actual mode=%0d br=%0b oc=%0b fr=%0b tc=%0b expected mode=%0d",
                 $time, mode, bridgeEn, ocCheckEn, freqReset, timerClear, refMode);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectMode(int exp, string tag);
    checks++;
    if (mode != 3'(exp)) begin
      fails++;
      $display("FAIL %s actual mode=%0d expected mode=%0d", tag, mode, exp);
    end
  endtask

  task automatic powerGood();
    supHi = 1; supLo = 1; busOn = 1; busOff = 1; sdHi = 0; sdLo = 0;
  endtask

  initial begin
    step(3);
    // R1: reset state
    checks++;
    if (mode != 3'd0 || bridgeEn || ocCheckEn || !freqReset || !timerClear) begin
      fails++;
      $display("FAIL R1 actual mode=%0d br=%0b oc=%0b fr=%0b tc=%0b expected 0/0/0/1/1",
               mode, bridgeEn, ocCheckEn, freqReset, timerClear);
    end
    rstN = 1;
    step(2);

    // R2: partial start conditions hold lockout
    supHi = 1; supLo = 1; busOn = 0; busOff = 1; step(6); expectMode(0, "R2 no bus");
    busOn = 1; sdLo = 1; step(6); expectMode(0, "R2 shutdown high");
    sdLo = 0; supHi = 0; step(6); expectMode(0, "R2 supply low");
    supHi = 1; step(2); expectMode(0, "R2 latency two");
    step(1); expectMode(1, "R2 latency three");

    // R5, R7: over-current and dim flag ignored in preheat
    oc = 1; dimT = 1; step(4); expectMode(1, "R5 oc masked in preheat");
    oc = 0; dimT = 0;
    // R4: preheat reaches ignition
    step(PH); expectMode(2, "R4 preheat end");
    checks++;
    if (!ocCheckEn) begin fails++; $display("FAIL R8 actual ocCheckEn=0 expected 1"); end
    // R7: ignition to dim
    dimT = 1; step(5); expectMode(3, "R7 dim entry");
    dimT = 0;
    // R5: over-current in dim gives fault
    oc = 1; step(5); expectMode(4, "R5 oc fault in dim");
    oc = 0;
    // R9: releases that must not clear the fault
    busOff = 0; busOn = 0; ot = 0; step(8); expectMode(4, "R9 latched");
    busOff = 1; busOn = 1;
    // R9: shutdown cycling clears, then restart in preheat
    sdHi = 1; sdLo = 1; step(5); expectMode(0, "R9 shutdown clears");
    sdHi = 0; sdLo = 0; step(5); expectMode(1, "R9 restart preheat");

    // R6: over-temperature in preheat
    ot = 1; step(5); expectMode(4, "R6 hot fault");
    ot = 0; step(4); expectMode(4, "R9 hot released");
    // R9: supply drop clears
    supLo = 0; supHi = 0; step(5); expectMode(0, "R9 supply cycle");
    powerGood(); step(5); expectMode(1, "R9 supply restart");

    // R3: bus drop from dim
    step(PH + 2); dimT = 1; step(5); expectMode(3, "R3 setup dim"); dimT = 0;
    busOff = 0; busOn = 0; step(5); expectMode(0, "R3 bus drop");
    powerGood(); step(PH + 6); expectMode(2, "R3 back to ignition");
    // R3: shutdown high from ignition
    sdHi = 1; sdLo = 1; step(5); expectMode(0, "R3 lamp removed");
    powerGood(); step(PH + 6); expectMode(2, "R10 setup ignition");
    // R10: coincident drop-out and faults
    busOff = 0; busOn = 0; ot = 1; oc = 1; step(5); expectMode(0, "R10 lockout wins");
    ot = 0; oc = 0; powerGood(); step(5); expectMode(1, "R10 recovers");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule